// File: doc/BRIEF.md
# Synchronous Bus Slave RAM

This block is a word-addressed RAM on the slave side of a synchronous external-memory bus. A host processor reaches it through an active-low chip select, separate active-low write and read strobes, a 20-bit word address and a shared bidirectional 32-bit data bus. All of these are sampled on the rising edge of the bus clock that the host supplies.

A write is stored on the same clock edge that qualifies it. A read is accepted on one edge, and its data appears on the shared bus two clocks later. The slave drives the bus only for the single clock period in which it returns that data. At all other times it leaves the bus free, so that the host can drive write data without contention. Back-to-back reads are pipelined, so a read can be accepted on every clock.

Top module: `sync_bus_ram`

## Requirements
- R1: While reset is asserted, and after reset is released until the first accepted read has gone through the pipeline, `bus_oe` is 0 and no read data is presented. A reset asserted while a read is in flight cancels that read.
- R2: A write is accepted on a rising edge where `cs_n`=0 and `we_n`=0. The value on `bus_data` at that edge is stored at once (zero latency), so a read accepted on the very next edge returns the new value.
- R3: A read is accepted on a rising edge N where `cs_n`=0, `re_n`=0 and `we_n`=1. The stored word is driven on `bus_data` with `bus_oe`=1 during the period from edge N+1 to edge N+2, so it is valid at edge N+2.
- R4: `bus_oe` is 1 only in periods that belong to an accepted read. In every other period the slave releases the data bus.
- R5: When `we_n` and `re_n` are both 0 with `cs_n`=0, only the write takes place. No read is issued and `bus_oe` stays 0 for that access.
- R6: While `cs_n`=1, the strobes are ignored: nothing is stored and no read is issued.
- R7: Reads accepted on consecutive edges each return their own word, on consecutive periods, two clocks after their own accept edge.
- R8: The low `RAM_AW` address bits (8 by default, giving 256 words) select the word. The higher address bits are ignored, so addresses that differ only in those bits reach the same word.
- R9: Incrementing 32-bit words written to consecutive word offsets all read back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock from the host; all sampling is on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write strobe |
| re_n | input | 1 | Active-low read strobe |
| addr | input | 20 | Word address from the host |
| bus_data | inout | 32 | Shared data bus: write data in, read data out |
| bus_oe | output | 1 | High while the slave drives `bus_data` |

## Verification
Two situations are hard to reach from the ports. The first is a fully loaded read pipeline: one read is being presented while the next is being fetched and a third is being accepted. The second is a read that is cut off by reset before its data appears. The stimulus keeps the read strobe low for several consecutive clocks over scattered addresses. It also issues a read and asserts reset on the following half-cycle, then watches that `bus_oe` stays low afterwards. A scoreboard records the cycle in which each read's data is due, so that an early, late or stray drive shows up as a mismatch against that cycle.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  localparam int BUS_W  = 32;
  localparam int HOST_AW = 20;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } bus_op_e;

  // Write wins over read; chip select gates both.
  function automatic bus_op_e classify(input logic sel_n, input logic wr_n, input logic rd_n);
    if (sel_n)      return OP_IDLE;
    else if (!wr_n) return OP_WRITE;
    else if (!rd_n) return OP_READ;
    else            return OP_IDLE;
  endfunction

  // Word index: keep only the bits that the RAM depth needs.
  function automatic logic [HOST_AW-1:0] word_slot(input logic [HOST_AW-1:0] a, input int unsigned bits);
    logic [HOST_AW-1:0] mask;
    mask = (HOST_AW'(1) << bits) - HOST_AW'(1);
    return a & mask;
  endfunction
endpackage

// File: rtl/sbr_strobe_decode.sv
module sbr_strobe_decode
  import sbr_pkg::*;
#(
  parameter int AW  = HOST_AW,
  parameter int RAW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           we_n,
  input  logic           re_n,
  input  logic [AW-1:0]  addr,
  output logic           wr_fire,
  output logic           rd_fire,
  output logic [RAW-1:0] word_idx
);
  bus_op_e           op;
  logic [HOST_AW-1:0] slot;

  always_comb begin
    op       = classify(cs_n, we_n, re_n);
    wr_fire  = (op == OP_WRITE);
    rd_fire  = (op == OP_READ);
    slot     = word_slot(HOST_AW'(addr), RAW);
    word_idx = slot[RAW-1:0];
  end

  // R5
  wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !we_n && !re_n) |-> (wr_fire && !rd_fire));

  // R6
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!wr_fire && !rd_fire));
endmodule

// File: rtl/sbr_ram.sv
module sbr_ram #(
  parameter int DW  = 32,
  parameter int RAW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [RAW-1:0] idx,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata
);
  localparam int DEPTH = 1 << RAW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rdata <= mem[idx];
  end

  // R2
  wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(idx)] == $past(wdata)));
endmodule

// File: rtl/sbr_rd_pipe.sv
module sbr_rd_pipe #(
  parameter int DW  = 32,
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_fire,
  input  logic [DW-1:0] ram_q,
  output logic          drive_en,
  output logic [DW-1:0] drive_data
);
  localparam int DSTG = (LAT > 1) ? LAT - 1 : 1;

  logic [LAT-1:0] vld;
  logic [DW-1:0]  dreg [DSTG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else        vld <= {vld[LAT-2:0], rd_fire};
  end

  always_ff @(posedge clk) dreg[0] <= ram_q;

  generate
    for (genvar s = 1; s < DSTG; s++) begin : g_dstg
      always_ff @(posedge clk) dreg[s] <= dreg[s-1];
    end
  endgenerate

  assign drive_en   = vld[LAT-1];
  assign drive_data = dreg[DSTG-1];

  generate
    if (LAT == 2) begin : g_lat2_chk
      // R3
      rd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |=> ##1 drive_en);
      // R4
      no_stray_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> $past(rd_fire, 2));
    end
  endgenerate

  // R1
  rst_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !drive_en);
endmodule

// File: rtl/sync_bus_ram.sv
module sync_bus_ram
  import sbr_pkg::*;
#(
  parameter int RAM_AW = 8,
  parameter int RD_LAT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               we_n,
  input  logic               re_n,
  input  logic [HOST_AW-1:0] addr,
  inout  wire  [BUS_W-1:0]   bus_data,
  output logic               bus_oe
);
  logic              wr_fire;
  logic              rd_fire;
  logic [RAM_AW-1:0] word_idx;
  logic [BUS_W-1:0]  ram_q;
  logic [BUS_W-1:0]  drive_data;
  logic              drive_en;

  sbr_strobe_decode #(.AW(HOST_AW), .RAW(RAM_AW)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .we_n     (we_n),
    .re_n     (re_n),
    .addr     (addr),
    .wr_fire  (wr_fire),
    .rd_fire  (rd_fire),
    .word_idx (word_idx)
  );

  sbr_ram #(.DW(BUS_W), .RAW(RAM_AW)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_fire),
    .rd_en (rd_fire),
    .idx   (word_idx),
    .wdata (bus_data),
    .rdata (ram_q)
  );

  sbr_rd_pipe #(.DW(BUS_W), .LAT(RD_LAT)) u_pipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_fire    (rd_fire),
    .ram_q      (ram_q),
    .drive_en   (drive_en),
    .drive_data (drive_data)
  );

  assign bus_data = drive_en ? drive_data : {BUS_W{1'bz}};
  assign bus_oe   = drive_en;

  // R5
  wr_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> !rd_fire);
endmodule

// File: tb/tb_sync_bus_ram.sv
module tb_sync_bus_ram;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        we_n = 1'b1;
  logic        re_n = 1'b1;
  logic [19:0] addr = '0;
  logic        host_en = 1'b0;
  logic [31:0] host_val = '0;
  wire  [31:0] bus;
  logic        bus_oe;

  assign bus = host_en ? host_val : 32'hz;

  sync_bus_ram dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .re_n(re_n),
    .addr(addr), .bus_data(bus), .bus_oe(bus_oe)
  );

  always #4 clk = ~clk;

  typedef struct { int due; logic [31:0] val; string tag; } exp_t;
  exp_t        sb[$];
  logic [31:0] model [256];
  int          cyc = 0;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cs_n = 1'b1; we_n = 1'b1; re_n = 1'b1; host_en = 1'b0;
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [31:0] d);
    @(negedge clk);
    cs_n = 1'b0; we_n = 1'b0; re_n = 1'b1; addr = a;
    host_en = 1'b1; host_val = d;
    model[a % 256] = d;
  endtask

  task automatic rd(input logic [19:0] a, input string tag);
    exp_t e;
    @(negedge clk);
    cs_n = 1'b0; we_n = 1'b1; re_n = 1'b0; addr = a; host_en = 1'b0;
    e.due = cyc + 2; e.val = model[a % 256]; e.tag = tag;
    sb.push_back(e);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      check(bus_oe == 1'b0, "R1 oe in reset", 32'(bus_oe), 0);
    end else if (sb.size() > 0 && sb[0].due == cyc) begin
      check(bus_oe == 1'b1, {sb[0].tag, " oe"}, 32'(bus_oe), 1);
      check(bus == sb[0].val, {sb[0].tag, " data"}, bus, sb[0].val);
      void'(sb.pop_front());
    end else begin
      check(bus_oe == 1'b0, "R4 stray drive", 32'(bus_oe), 0);
      if (sb.size() > 0 && sb[0].due < cyc) begin
        check(1'b0, {sb[0].tag, " missed"}, 0, sb[0].val);
        void'(sb.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 32'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(bus_oe == 1'b0, "R1 after reset", 32'(bus_oe), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    // clear the whole RAM so the model starts known
    for (int i = 0; i < 256; i++) wr(20'(i), 32'h0);
    idle(1);
    // R9 incrementing pattern with single read-back
    for (int i = 0; i < 64; i++) begin
      wr(20'(i), 32'h1111_1111 + 32'(i));
      rd(20'(i), "R9 roundtrip");
      idle(3);
    end
    // R2 write then read on the very next edge
    wr(20'h00A5, 32'hDEAD_BEEF);
    rd(20'h00A5, "R2 zero latency");
    idle(3);
    // R3 single read at an isolated address
    rd(20'h0003, "R3 single read");
    idle(4);
    // R7 back-to-back reads
    for (int i = 0; i < 8; i++) rd(20'(i * 7), "R7 pipelined");
    idle(4);
    // R5 both strobes: write only
    @(negedge clk);
    cs_n = 1'b0; we_n = 1'b0; re_n = 1'b0; addr = 20'h0010;
    host_en = 1'b1; host_val = 32'hCAFE_0010; model[16] = 32'hCAFE_0010;
    idle(4);
    rd(20'h0010, "R5 write stored");
    idle(4);
    // R6 deselected strobes ignored
    @(negedge clk);
    cs_n = 1'b1; we_n = 1'b0; re_n = 1'b1; addr = 20'h0011;
    host_en = 1'b1; host_val = 32'h5555_AAAA;
    @(negedge clk);
    cs_n = 1'b1; we_n = 1'b1; re_n = 1'b0; host_en = 1'b0;
    idle(4);
    rd(20'h0011, "R6 deselected");
    idle(4);
    // R8 upper address bits ignored
    wr(20'hABC42, 32'h0BAD_F00D);
    idle(1);
    rd(20'h00042, "R8 alias low");
    rd(20'h12342, "R8 alias high");
    idle(4);
    // R1 reset cancels an in-flight read
    rd(20'h0005, "R1 cancelled");
    @(negedge clk);
    cs_n = 1'b1; re_n = 1'b1; rst_n = 1'b0;
    sb.delete();
    idle(2);
    @(negedge clk); rst_n = 1'b1;
    idle(4);
    check(bus_oe == 1'b0, "R1 after cancel", 32'(bus_oe), 0);
    rd(20'h0005, "R1 fresh read");
    idle(4);
    check(sb.size() == 0, "R4 queue drained", 32'(sb.size()), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule